// File: doc/BRIEF.md
# Transmit Link Phase Sequencer

This block decides, octet by octet, what a transmit lane of a JESD204B-style converter link carries. After reset the lane sends comma characters for code group synchronization (CGS). Once the receiver drops its synchronization request, the lane moves into the initial lane alignment sequence (ILAS) and then into user data. A long enough request during data returns the lane to CGS. One octet is produced per clock. A free-running frame counter and a free-running multiframe counter set the timing of every phase change and every marker character.

The same block also applies the register-level controls around the link. These are the request polarity, software overrides that force CGS or force the link to run, ILAS off/once/looped, frame alignment character substitution, and the symbol sent while the converters are in standby. The 8b/10b encoder, the scrambler and the contents of the ILAS configuration octets are outside this block. ILAS body octets carry the octet's position within its multiframe as a stand-in. The outputs are the octet value, a control-character flag that tells the encoder which octets are K codes, and the current phase.

Top module: `jtx_link_sequencer`

## Requirements
- R1: After reset the phase output is 0 (CGS). In CGS every octet is 0xBC (K28.5) with ctrl_k high.
- R2: With sync_act_high at 0 the request is active when sync_in is low. With sync_act_high at 1 it is active when sync_in is high.
- R3: A sync_ctl value of 2'b10 makes the request active whatever the pin does. A value of 2'b11 makes it inactive whatever the pin does. Values 2'b00 and 2'b01 follow the pin.
- R4: The lane leaves CGS only at the clock edge that ends the last octet of a multiframe while the request is inactive. The first octet after the change is octet 0 of a multiframe. Counters start at multiframe octet 0 on the first clock after reset.
- R5: With ilas_mode at 2'b00 the lane goes from CGS straight to data (phase 2) and never shows phase 1.
- R6: With ilas_mode at 2'b01, ILAS (phase 1) lasts ILAS_MULTIFRAMES multiframes and then data follows. Within ILAS, multiframe octet 0 is 0x1C (K28.0) and the last octet is 0x7C (K28.3), both with ctrl_k high. Every other octet is its index within the multiframe, with ctrl_k low.
- R7: With ilas_mode at 2'b11, ILAS repeats without end while the request stays inactive.
- R8: An active request during ILAS returns the lane to CGS on the next octet.
- R9: During data, a request held for SYNC_HOLD_FRAMES × OCTETS_PER_FRAME consecutive octets returns the lane to CGS on the next octet. A shorter request has no effect.
- R10: During data with no substitution, octet_out equals data_in and ctrl_k is low. The phase output is 2.
- R11: During data with fa_disable low, the last octet of each frame is replaced. With fa_long low the replacement is always 0xFC (K28.7). With fa_long high it is 0x7C (K28.3) at the end of a multiframe and 0xFC elsewhere. ctrl_k is high in both cases. With fa_disable high no octet is replaced.
- R12: During data with standby high, every octet is 0x00 with ctrl_k low when standby_comma is 0. It is 0xBC with ctrl_k high when standby_comma is 1. Standby takes priority over R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Receiver synchronization request pin |
| sync_act_high | input | 1 | Request polarity: 0 active low, 1 active high |
| sync_ctl | input | 2 | Override: 00/01 follow pin, 10 force request, 11 force release |
| ilas_mode | input | 2 | 00 no ILAS, 01 ILAS once, 11 ILAS looped |
| fa_disable | input | 1 | 1 turns off frame alignment substitution |
| fa_long | input | 1 | 1 uses K28.3 at multiframe ends and K28.7 at other frame ends |
| standby | input | 1 | Converters in standby |
| standby_comma | input | 1 | Standby symbol: 0 zero samples, 1 K28.5 |
| data_in | input | 8 | User data octet |
| octet_out | output | 8 | Octet for the encoder |
| ctrl_k | output | 1 | Octet is a control character |
| phase_out | output | 2 | 0 CGS, 1 ILAS, 2 data |

## Verification
The octet outputs are combinational from the registered phase, the counters and the current control inputs. A change of a control input shows on the same octet. A phase change decided at a rising edge shows on the octet that starts at that edge. So an ILAS start is due one octet after a multiframe's last octet, and a return to CGS is due one octet after the request is seen in ILAS, or after the hold count is reached in data. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares phase, octet and flag at each falling edge, when the inputs have been stable for half a period. Scenario checks are likewise taken at falling edges, a known number of octets after each input change.

// File: rtl/jtx_seq_pkg.sv
package jtx_seq_pkg;

   typedef enum logic [1:0] {
      PH_CGS  = 2'd0,
      PH_ILAS = 2'd1,
      PH_DATA = 2'd2
   } phase_e;

   localparam logic [7:0] K28_0 = 8'h1C;
   localparam logic [7:0] K28_3 = 8'h7C;
   localparam logic [7:0] K28_5 = 8'hBC;
   localparam logic [7:0] K28_7 = 8'hFC;

   localparam logic [1:0] SYNC_FORCE_CGS = 2'b10;
   localparam logic [1:0] SYNC_FORCE_RUN = 2'b11;

   localparam logic [1:0] ILAS_OFF  = 2'b00;
   localparam logic [1:0] ILAS_LOOP = 2'b11;

endpackage

// File: rtl/jtx_frame_ctr.sv
module jtx_frame_ctr #(
   parameter int OCTETS_PER_FRAME = 2,
   parameter int FRAMES_PER_MF    = 4,
   localparam int MF_OCTETS = OCTETS_PER_FRAME * FRAMES_PER_MF,
   localparam int PW        = (MF_OCTETS > 1) ? $clog2(MF_OCTETS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          frame_end,
   output logic          mf_start,
   output logic          mf_end,
   output logic [PW-1:0] mf_pos
);

   if (OCTETS_PER_FRAME < 1 || FRAMES_PER_MF < 1 || MF_OCTETS < 2) begin : g_bad_geometry
      $error("jtx_frame_ctr: a multiframe needs at least two octets");
   end

   logic [PW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (pos_q == PW'(MF_OCTETS - 1))
         pos_q <= '0;
      else
         pos_q <= pos_q + 1'b1;
   end

   assign mf_pos   = pos_q;
   assign mf_start = (pos_q == '0);
   assign mf_end   = (pos_q == PW'(MF_OCTETS - 1));

   if (OCTETS_PER_FRAME == 1) begin : g_single_octet
      assign frame_end = 1'b1;
   end else begin : g_octet_ctr
      localparam int OW = $clog2(OCTETS_PER_FRAME);
      logic [OW-1:0] oct_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            oct_q <= '0;
         else if (oct_q == OW'(OCTETS_PER_FRAME - 1))
            oct_q <= '0;
         else
            oct_q <= oct_q + 1'b1;
      end

      assign frame_end = (oct_q == OW'(OCTETS_PER_FRAME - 1));
   end

endmodule

// File: rtl/jtx_sync_filter.sv
module jtx_sync_filter
   import jtx_seq_pkg::*;
#(
   parameter int HOLD_CYCLES = 8,
   localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       act_high,
   input  logic [1:0] ctl,
   output logic       req_now,
   output logic       req_long
);

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("jtx_sync_filter: HOLD_CYCLES must be at least 1");
   end

   logic pin_req;

   assign pin_req = act_high ? sync_in : ~sync_in;

   always_comb begin
      case (ctl)
         SYNC_FORCE_CGS: req_now = 1'b1;
         SYNC_FORCE_RUN: req_now = 1'b0;
         default:        req_now = pin_req;
      endcase
   end

   if (HOLD_CYCLES == 1) begin : g_no_filter
      assign req_long = req_now;
   end else begin : g_run_ctr
      logic [HW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            run_q <= '0;
         else if (!req_now)
            run_q <= '0;
         else if (run_q != HW'(HOLD_CYCLES))
            run_q <= run_q + 1'b1;
      end

      assign req_long = req_now && (run_q >= HW'(HOLD_CYCLES - 1));
   end

endmodule

// File: rtl/jtx_link_fsm.sv
module jtx_link_fsm
   import jtx_seq_pkg::*;
#(
   parameter int ILAS_MULTIFRAMES = 4,
   localparam int IW = (ILAS_MULTIFRAMES > 1) ? $clog2(ILAS_MULTIFRAMES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_now,
   input  logic       req_long,
   input  logic       mf_end,
   input  logic [1:0] ilas_mode,
   output phase_e     phase
);

   if (ILAS_MULTIFRAMES < 1) begin : g_bad_ilas
      $error("jtx_link_fsm: ILAS needs at least one multiframe");
   end

   phase_e        ph_q, ph_d;
   logic [IW-1:0] mfc_q, mfc_d;
   logic          last_mf;

   assign last_mf = (mfc_q == IW'(ILAS_MULTIFRAMES - 1));

   always_comb begin
      ph_d  = ph_q;
      mfc_d = mfc_q;
      case (ph_q)
         PH_CGS: begin
            if (!req_now && mf_end) begin
               mfc_d = '0;
               ph_d  = (ilas_mode == ILAS_OFF) ? PH_DATA : PH_ILAS;
            end
         end
         PH_ILAS: begin
            if (req_now) begin
               ph_d = PH_CGS;
            end else if (mf_end) begin
               if (last_mf) begin
                  mfc_d = '0;
                  if (ilas_mode != ILAS_LOOP)
                     ph_d = PH_DATA;
               end else begin
                  mfc_d = mfc_q + 1'b1;
               end
            end
         end
         PH_DATA: begin
            if (req_long)
               ph_d = PH_CGS;
         end
         default: ph_d = PH_CGS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_CGS;
         mfc_q <= '0;
      end else begin
         ph_q  <= ph_d;
         mfc_q <= mfc_d;
      end
   end

   assign phase = ph_q;

endmodule

// File: rtl/jtx_symbol_mux.sv
module jtx_symbol_mux
   import jtx_seq_pkg::*;
#(
   parameter int PW = 3
) (
   input  phase_e        phase,
   input  logic          frame_end,
   input  logic          mf_start,
   input  logic          mf_end,
   input  logic [PW-1:0] mf_pos,
   input  logic [7:0]    data_in,
   input  logic          standby,
   input  logic          standby_comma,
   input  logic          fa_disable,
   input  logic          fa_long,
   output logic [7:0]    octet,
   output logic          ctrl_k
);

   logic [7:0] fill;

   if (PW >= 8) begin : g_wide_pos
      assign fill = mf_pos[7:0];
   end else begin : g_narrow_pos
      assign fill = {{(8 - PW){1'b0}}, mf_pos};
   end

   always_comb begin
      octet  = K28_5;
      ctrl_k = 1'b1;
      case (phase)
         PH_ILAS: begin
            if (mf_start) begin
               octet = K28_0;
            end else if (mf_end) begin
               octet = K28_3;
            end else begin
               octet  = fill;
               ctrl_k = 1'b0;
            end
         end
         PH_DATA: begin
            if (standby) begin
               octet  = standby_comma ? K28_5 : 8'h00;
               ctrl_k = standby_comma;
            end else if (!fa_disable && frame_end) begin
               octet = (fa_long && mf_end) ? K28_3 : K28_7;
            end else begin
               octet  = data_in;
               ctrl_k = 1'b0;
            end
         end
         default: begin
            octet  = K28_5;
            ctrl_k = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/jtx_link_sequencer.sv
module jtx_link_sequencer
   import jtx_seq_pkg::*;
#(
   parameter int OCTETS_PER_FRAME = 2,
   parameter int FRAMES_PER_MF    = 4,
   parameter int ILAS_MULTIFRAMES = 4,
   parameter int SYNC_HOLD_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       sync_act_high,
   input  logic [1:0] sync_ctl,
   input  logic [1:0] ilas_mode,
   input  logic       fa_disable,
   input  logic       fa_long,
   input  logic       standby,
   input  logic       standby_comma,
   input  logic [7:0] data_in,
   output logic [7:0] octet_out,
   output logic       ctrl_k,
   output logic [1:0] phase_out
);

   localparam int MF_OCTETS   = OCTETS_PER_FRAME * FRAMES_PER_MF;
   localparam int PW          = (MF_OCTETS > 1) ? $clog2(MF_OCTETS) : 1;
   localparam int HOLD_CYCLES = SYNC_HOLD_FRAMES * OCTETS_PER_FRAME;

   if (SYNC_HOLD_FRAMES < 1) begin : g_bad_hold_frames
      $error("jtx_link_sequencer: SYNC_HOLD_FRAMES must be at least 1");
   end

   logic          frame_end, mf_start, mf_end;
   logic [PW-1:0] mf_pos;
   logic          req_now, req_long;
   phase_e        phase;

   jtx_frame_ctr #(
      .OCTETS_PER_FRAME (OCTETS_PER_FRAME),
      .FRAMES_PER_MF    (FRAMES_PER_MF)
   ) u_frame_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .mf_start  (mf_start),
      .mf_end    (mf_end),
      .mf_pos    (mf_pos)
   );

   jtx_sync_filter #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_sync_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_in),
      .act_high (sync_act_high),
      .ctl      (sync_ctl),
      .req_now  (req_now),
      .req_long (req_long)
   );

   jtx_link_fsm #(
      .ILAS_MULTIFRAMES (ILAS_MULTIFRAMES)
   ) u_link_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_now   (req_now),
      .req_long  (req_long),
      .mf_end    (mf_end),
      .ilas_mode (ilas_mode),
      .phase     (phase)
   );

   jtx_symbol_mux #(
      .PW (PW)
   ) u_symbol_mux (
      .phase         (phase),
      .frame_end     (frame_end),
      .mf_start      (mf_start),
      .mf_end        (mf_end),
      .mf_pos        (mf_pos),
      .data_in       (data_in),
      .standby       (standby),
      .standby_comma (standby_comma),
      .fa_disable    (fa_disable),
      .fa_long       (fa_long),
      .octet         (octet_out),
      .ctrl_k        (ctrl_k)
   );

   assign phase_out = phase;

endmodule

// File: rtl/jtx_link_sequencer_chk.sv
module jtx_link_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] sync_ctl,
   input logic [1:0] ilas_mode,
   input logic       standby,
   input logic       standby_comma,
   input logic [7:0] octet_out,
   input logic       ctrl_k,
   input logic [1:0] phase_out
);

   assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_out != 2'd3);

   assert_cgs_comma_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phase_out == 2'd0 |-> (octet_out == 8'hBC && ctrl_k));

   assert_ilas_opens_k28_0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out == 2'd1 && $past(phase_out) == 2'd0) |-> (octet_out == 8'h1C && ctrl_k));

   assert_force_cgs_in_ilas_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ctl == 2'b10 && phase_out == 2'd1) |=> phase_out == 2'd0);

   assert_force_run_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ctl == 2'b11 && phase_out == 2'd2) |=> phase_out == 2'd2);

   assert_no_ilas_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ilas_mode == 2'b00 && phase_out == 2'd0) |=> phase_out != 2'd1);

   assert_standby_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_out == 2'd2 && standby && !standby_comma) |-> (octet_out == 8'h00 && !ctrl_k));

endmodule

bind jtx_link_sequencer jtx_link_sequencer_chk u_chk (.*);

// File: tb/tb_jtx_link_sequencer.sv
`timescale 1ns/1ps
module tb_jtx_link_sequencer;

   localparam int F    = 2;
   localparam int K    = 4;
   localparam int NI   = 4;
   localparam int HF   = 4;
   localparam int MFO  = F * K;
   localparam int HOLD = HF * F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       sync_act_high = 1'b0;
   logic [1:0] sync_ctl = 2'b00;
   logic [1:0] ilas_mode = 2'b01;
   logic       fa_disable = 1'b1;
   logic       fa_long = 1'b0;
   logic       standby = 1'b0;
   logic       standby_comma = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic [7:0] octet_out;
   logic       ctrl_k;
   logic [1:0] phase_out;

   always #4 clk = ~clk;

   jtx_link_sequencer #(
      .OCTETS_PER_FRAME (F),
      .FRAMES_PER_MF    (K),
      .ILAS_MULTIFRAMES (NI),
      .SYNC_HOLD_FRAMES (HF)
   ) dut (
      .clk (clk), .rst_n (rst_n), .sync_in (sync_in), .sync_act_high (sync_act_high),
      .sync_ctl (sync_ctl), .ilas_mode (ilas_mode), .fa_disable (fa_disable),
      .fa_long (fa_long), .standby (standby), .standby_comma (standby_comma),
      .data_in (data_in), .octet_out (octet_out), .ctrl_k (ctrl_k), .phase_out (phase_out)
   );

   int checks = 0;
   int errors = 0;
   int ilas_seen = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // behavioural reference model
   int m_pos = 0, m_ph = 0, m_ic = 0, m_hold = 0;

   function automatic bit model_req();
      if (sync_ctl == 2'b10) return 1'b1;
      if (sync_ctl == 2'b11) return 1'b0;
      return sync_act_high ? sync_in : !sync_in;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_ph = 0; m_ic = 0; m_hold = 0;
      end else begin
         int  np;
         bit  r;
         bit  mfe;
         r   = model_req();
         mfe = (m_pos == MFO - 1);
         np  = m_ph;
         if (m_ph == 0) begin
            if (!r && mfe) begin
               m_ic = 0;
               np = (ilas_mode == 2'b00) ? 2 : 1;
            end
         end else if (m_ph == 1) begin
            if (r) np = 0;
            else if (mfe) begin
               if (m_ic == NI - 1) begin
                  m_ic = 0;
                  if (ilas_mode != 2'b11) np = 2;
               end else m_ic++;
            end
         end else begin
            if (r && m_hold >= HOLD - 1) np = 0;
         end
         m_hold = r ? ((m_hold < HOLD) ? m_hold + 1 : HOLD) : 0;
         m_pos  = (m_pos + 1) % MFO;
         m_ph   = np;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int    eo, ek;
         string tag;
         if (m_ph == 0) begin
            eo = 8'hBC; ek = 1; tag = "R1 cgs octet";
         end else if (m_ph == 1) begin
            tag = "R6 ilas octet";
            if (m_pos == 0)            begin eo = 8'h1C; ek = 1; end
            else if (m_pos == MFO - 1) begin eo = 8'h7C; ek = 1; end
            else                       begin eo = m_pos % 256; ek = 0; end
         end else if (standby) begin
            tag = "R12 standby octet";
            eo = standby_comma ? 8'hBC : 8'h00; ek = standby_comma ? 1 : 0;
         end else if (!fa_disable && (m_pos % F) == F - 1) begin
            tag = "R11 alignment octet";
            eo = (fa_long && m_pos == MFO - 1) ? 8'h7C : 8'hFC; ek = 1;
         end else begin
            tag = "R10 data octet";
            eo = data_in; ek = 0;
         end
         check(phase_out == 2'(m_ph), "R4 phase track", phase_out, m_ph);
         check(octet_out == 8'(eo) && ctrl_k == ek[0], tag, {ctrl_k, octet_out}, {ek[0], 8'(eo)});
         if (phase_out == 2'd1) ilas_seen++;
      end
   end

   initial forever begin
      @(negedge clk);
      #1 data_in = 8'($urandom);
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", checks, 0);
      report();
   end

   initial begin
      step(3);
      #1 rst_n = 1'b1;
      step(1);
      check(phase_out == 2'd0 && octet_out == 8'hBC && ctrl_k, "R1 reset state", phase_out, 0);
      step(20);
      check(phase_out == 2'd0, "R1 stays in CGS while requested", phase_out, 0);

      // ILAS once then data
      #1 ilas_seen = 0; sync_in = 1'b1;
      step(60);
      check(ilas_seen == NI * MFO, "R6 ILAS length", ilas_seen, NI * MFO);
      check(phase_out == 2'd2, "R6 data after ILAS", phase_out, 2);

      // frame alignment schemes
      #1 fa_disable = 1'b0;
      step(24);
      #1 fa_long = 1'b1;
      step(24);

      // standby symbols
      #1 standby = 1'b1;
      step(12);
      #1 standby_comma = 1'b1;
      step(12);
      #1 standby = 1'b0;
      step(4);

      // short and long requests in data
      #1 sync_in = 1'b0;
      step(HOLD - 1);
      #1 sync_in = 1'b1;
      step(4);
      check(phase_out == 2'd2, "R9 short request ignored", phase_out, 2);
      #1 sync_in = 1'b0;
      step(HOLD + 2);
      check(phase_out == 2'd0, "R9 long request returns to CGS", phase_out, 0);

      // polarity
      #1 sync_act_high = 1'b1; sync_in = 1'b1;
      step(30);
      check(phase_out == 2'd0, "R2 active-high request holds CGS", phase_out, 0);
      #1 sync_in = 1'b0;
      step(50);
      check(phase_out == 2'd2, "R2 active-high release runs link", phase_out, 2);

      // overrides
      #1 sync_ctl = 2'b10;
      step(HOLD + 2);
      check(phase_out == 2'd0, "R3 forced CGS", phase_out, 0);
      #1 sync_ctl = 2'b11; sync_in = 1'b1;
      step(50);
      check(phase_out == 2'd2, "R3 forced run ignores pin", phase_out, 2);
      #1 sync_ctl = 2'b00;
      step(HOLD + 2);
      check(phase_out == 2'd0, "R3 pin followed again", phase_out, 0);

      // no ILAS
      #1 ilas_mode = 2'b00; ilas_seen = 0; sync_in = 1'b0;
      step(20);
      check(ilas_seen == 0, "R5 no ILAS octets", ilas_seen, 0);
      check(phase_out == 2'd2, "R5 straight to data", phase_out, 2);

      // looped ILAS
      #1 sync_in = 1'b1;
      step(HOLD + 2);
      #1 ilas_mode = 2'b11; sync_in = 1'b0; ilas_seen = 0;
      step(100);
      check(phase_out == 2'd1, "R7 ILAS keeps looping", phase_out, 1);
      check(ilas_seen >= 90, "R7 ILAS octet count", ilas_seen, 90);

      // request during ILAS
      #1 sync_in = 1'b1;
      step(1);
      check(phase_out == 2'd0, "R8 request aborts ILAS", phase_out, 0);

      // entry point of ILAS
      #1 ilas_mode = 2'b01; sync_in = 1'b0;
      for (int i = 0; i < 20 && phase_out == 2'd0; i++) step(1);
      check(phase_out == 2'd1 && octet_out == 8'h1C, "R4 ILAS starts on multiframe octet 0",
            octet_out, 8'h1C);
      step(8);
      report();
   end

endmodule